// File: doc/BRIEF.md
# Rotate-Mask Move Sequencer

This block is the whole control and datapath of a tiny computer whose only operation moves bits from one memory word into another. It holds a 256-bit instruction state split into four 64-bit fields: a control field on top, then the address of the following instruction, then the destination word address, and the source word address at the bottom. The control field carries a 32-bit mask, a 5-bit rotate count and a 3-bit step number. Above those sit opcode, flag, terminate and create bits, which are carried along but have no effect.

Each instruction runs as four passes, one per clock. The sequencer requests the source word, then requests the destination word, then writes back a merged word, then fetches the next 256-bit instruction. Memory reads return their data one cycle after the strobe. Because of this, the source request of a new instruction takes its address straight from the fetch data bus, in the same pass that loads the state. The source word, once captured, overwrites the low 32 bits of the source-address field. The destination word overwrites the 32 bits above that. The merged word is the source word rotated left, with the mask choosing, bit by bit, between that rotated word and the old destination word.

Top module: `rmm_sequencer`

## Requirements
- R1: While reset (active-low, synchronous) is held, and in the first cycle after it is released, the block issues an instruction fetch (`ins_rd`=1) at address 0, with `mem_rd`=0 and `mem_wr`=0.
- R2: In the cycle after a fetch, the block issues a data read (`mem_rd`=1) at the source address, which is bits 63:0 of the 256-bit word on `ins_rdata`.
- R3: In the next cycle, the block issues a data read at the destination address, which is bits 127:64 of the fetched word.
- R4: In the next cycle, the block issues a write (`mem_wr`=1) to the same destination address.
- R5: The write data is the source word rotated left by the count in bits 228:224. Where the mask in bits 223:192 is 1, the bit comes from the rotated source word; where the mask is 0, the bit keeps the destination word. This also holds when source and destination are the same address, and for rotate counts 0 and 31.
- R6: In the next cycle, the block fetches the next instruction from the address in bits 191:128. The four-pass pattern then repeats with no idle cycle.
- R7: Bits 255:229 of a fetched word have no effect on any output. These are the opcode, flag number, flag function, terminate, create and the stored step bits. Every new instruction starts at the source-read pass.
- R8: At most one of `mem_rd`, `mem_wr` and `ins_rd` is high in any cycle.
- R9: Asserting reset in the middle of an instruction abandons it. The block fetches again from address 0 and then runs the instruction found there from its first pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_rd | output | 1 | 32-bit data read strobe; data arrives on `mem_rdata` the next cycle |
| mem_wr | output | 1 | 32-bit data write strobe |
| ins_rd | output | 1 | 256-bit instruction fetch strobe; word arrives on `ins_rdata` the next cycle |
| mem_addr | output | 64 | Shared address for reads, writes and fetches |
| mem_wdata | output | 32 | Merged write data |
| mem_rdata | input | 32 | Data read return |
| ins_rdata | input | 256 | Instruction fetch return |

## Verification
The bench builds the block with its default parameters: 64-bit fields and addresses and 32-bit data. This puts the full 64-bit address decode within reach. The test addresses have their upper bits set, so a truncated address path shows up on `mem_addr`. The 5-bit rotate field is exercised at both ends, 0 and 31. Because the control field is exactly 64 bits at this width, the ignored upper bits can be filled with junk to test that they have no effect. A case where source and destination are the same address checks that the merge takes its keep-bits from the second read.

// File: rtl/rmm_pkg.sv
// Package: shared pass encoding for the rotate-mask move sequencer.
// Assumes the 3-bit step field in the state uses its low two bits as the pass.
package rmm_pkg;

    // Pass number held in the low two step bits; the order is the behaviour.
    typedef enum logic [1:0] {
        PASS_SRC   = 2'd0,
        PASS_DST   = 2'd1,
        PASS_WR    = 2'd2,
        PASS_FETCH = 2'd3
    } pass_e;

    localparam int STEP_W = 3;

    // Step value that follows a given pass, with the top step bit kept at zero.
    function automatic logic [STEP_W-1:0] step_after(input pass_e p);
        logic [1:0] nxt;
        nxt = p + 2'd1;
        return {1'b0, nxt};
    endfunction

endpackage

// File: rtl/rmm_rotmask.sv
// Module: rotate-left the source word, then merge it into the kept word under a mask.
// Assumes DATA_W is a power of two, so the rotate count covers every position.
module rmm_rotmask #(
    parameter int DATA_W = 32,
    localparam int ROT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] src_word,
    input  logic [DATA_W-1:0] keep_word,
    input  logic [DATA_W-1:0] mask,
    input  logic [ROT_W-1:0]  rot,
    output logic [DATA_W-1:0] merged
);

    logic [2*DATA_W-1:0] doubled;
    logic [DATA_W-1:0]   rotated;

    // Rotate by shifting a doubled copy and keeping its upper half.
    always_comb begin
        doubled = {src_word, src_word} << rot;
        rotated = doubled[2*DATA_W-1:DATA_W];
    end

    // Per-bit select between rotated source and kept destination.
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign merged[b] = mask[b] ? rotated[b] : keep_word[b];
    end

    // Bits outside the mask must match the kept word (R5).
    always_comb begin
        p_keep_unmasked_r5: assert (((merged ^ keep_word) & ~mask) == '0);
    end

endmodule

// File: rtl/rmm_step_ctl.sv
// Module: decodes the step field of the state into the current pass and strobes.
// Assumes the state register forces the top step bit to zero on every update.
module rmm_step_ctl
    import rmm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STEP_W-1:0] step_q,
    output pass_e             pass,
    output logic [STEP_W-1:0] step_nxt,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic              fetch_stb
);

    // Pass decode and the step value that follows it.
    always_comb begin
        pass     = pass_e'(step_q[1:0]);
        step_nxt = step_after(pass);
    end

    // One strobe per pass; both read passes share the data read strobe.
    always_comb begin
        rd_stb    = 1'b0;
        wr_stb    = 1'b0;
        fetch_stb = 1'b0;
        unique case (pass)
            PASS_SRC, PASS_DST: rd_stb    = 1'b1;
            PASS_WR:            wr_stb    = 1'b1;
            PASS_FETCH:         fetch_stb = 1'b1;
        endcase
    end

    // The stored top step bit never leaves zero (R7).
    p_step_top_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step_q[STEP_W-1] == 1'b0);

    // Passes advance by exactly one each cycle (R6).
    p_pass_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> step_q[1:0] == $past(step_q[1:0]) + 2'd1);

endmodule

// File: rtl/rmm_state_reg.sv
// Module: 256-bit instruction state register.
// Loads a fetched word, then reuses the low source-address bits for the two
// read data words. Assumes 2*DATA_W <= FIELD_W and that the step field lies in
// the top field.
module rmm_state_reg
    import rmm_pkg::*;
#(
    parameter int FIELD_W  = 64,
    parameter int DATA_W   = 32,
    parameter int STEP_LSB = 229,
    localparam int STATE_W = 4 * FIELD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  pass_e              pass,
    input  logic [STEP_W-1:0]  step_nxt,
    input  logic [STATE_W-1:0] ins_word,
    input  logic [DATA_W-1:0]  rd_word,
    output logic [STATE_W-1:0] state_q
);

    localparam logic [STEP_W-1:0] BOOT_STEP = {1'b0, PASS_FETCH};

    // State update per pass; reset points the next address at zero, step at fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q                          <= '0;
            state_q[STEP_LSB +: STEP_W]      <= BOOT_STEP;
        end else begin
            unique case (pass)
                PASS_SRC: begin
                    state_q                     <= ins_word;
                    state_q[STEP_LSB +: STEP_W] <= step_nxt;
                end
                PASS_DST: begin
                    state_q[0 +: DATA_W]        <= rd_word;
                    state_q[STEP_LSB +: STEP_W] <= step_nxt;
                end
                PASS_WR: begin
                    state_q[DATA_W +: DATA_W]   <= rd_word;
                    state_q[STEP_LSB +: STEP_W] <= step_nxt;
                end
                PASS_FETCH: begin
                    state_q[STEP_LSB +: STEP_W] <= step_nxt;
                end
            endcase
        end
    end

    // The source word captured in the destination-read pass is held through the write (R5).
    p_from_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pass == PASS_WR) |=> state_q[0 +: DATA_W] == $past(state_q[0 +: DATA_W]));

endmodule

// File: rtl/rmm_sequencer.sv
// Module: top of the four-pass rotate-mask move sequencer.
// Per instruction: source read, destination read, merged write, next fetch.
// Assumes memory returns read and fetch data one cycle after the strobe and
// that ADDR_W <= FIELD_W.
module rmm_sequencer
    import rmm_pkg::*;
#(
    parameter int FIELD_W = 64,
    parameter int ADDR_W  = 64,
    parameter int DATA_W  = 32,
    localparam int STATE_W = 4 * FIELD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic               ins_rd,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic [STATE_W-1:0] ins_rdata
);

    localparam int ROT_W    = $clog2(DATA_W);
    localparam int SRC_LSB  = 0;
    localparam int DST_LSB  = FIELD_W;
    localparam int NEXT_LSB = 2 * FIELD_W;
    localparam int MASK_LSB = 3 * FIELD_W;
    localparam int ROT_LSB  = MASK_LSB + DATA_W;
    localparam int STEP_LSB = ROT_LSB + ROT_W;

    logic [STATE_W-1:0] state_q;
    pass_e              pass;
    logic [STEP_W-1:0]  step_nxt;

    rmm_step_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_q    (state_q[STEP_LSB +: STEP_W]),
        .pass      (pass),
        .step_nxt  (step_nxt),
        .rd_stb    (mem_rd),
        .wr_stb    (mem_wr),
        .fetch_stb (ins_rd)
    );

    rmm_state_reg #(
        .FIELD_W  (FIELD_W),
        .DATA_W   (DATA_W),
        .STEP_LSB (STEP_LSB)
    ) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .pass     (pass),
        .step_nxt (step_nxt),
        .ins_word (ins_rdata),
        .rd_word  (mem_rdata),
        .state_q  (state_q)
    );

    rmm_rotmask #(
        .DATA_W (DATA_W)
    ) u_merge (
        .src_word  (state_q[0 +: DATA_W]),
        .keep_word (mem_rdata),
        .mask      (state_q[MASK_LSB +: DATA_W]),
        .rot       (state_q[ROT_LSB +: ROT_W]),
        .merged    (mem_wdata)
    );

    // Address select: the source address comes off the fetch bus, before it is stored.
    always_comb begin
        unique case (pass)
            PASS_SRC:        mem_addr = ins_rdata[SRC_LSB +: ADDR_W];
            PASS_DST,
            PASS_WR:         mem_addr = state_q[DST_LSB +: ADDR_W];
            PASS_FETCH:      mem_addr = state_q[NEXT_LSB +: ADDR_W];
        endcase
    end

    // Reset leads to a fetch from address zero (R1).
    p_boot_fetch_r1: assert property (@(posedge clk)
        !rst_n |=> ins_rd && mem_addr == '0 && !mem_rd && !mem_wr);

    // A fetch is followed by a data read (R2).
    p_fetch_then_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ins_rd |=> mem_rd && !ins_rd);

    // A write targets the address read in the cycle before (R4).
    p_write_same_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(mem_rd) && mem_addr == $past(mem_addr));

    // A write is followed by a fetch (R6).
    p_write_then_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> ins_rd);

    // At most one strobe per cycle (R8).
    p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr, ins_rd}));

endmodule

// File: tb/sim_rmm_sequencer.sv
module sim_rmm_sequencer;

    typedef struct packed {
        logic [63:0] src;
        logic [63:0] dst;
        logic [4:0]  rot;
        logic [31:0] mask;
        logic [31:0] sword;
        logic [31:0] dword;
        logic [23:0] junk;
        logic [2:0]  stp;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, 5'd0,  32'hFFFF_FFFF, 32'h1234_5678, 32'hAAAA_AAAA, 24'h0,      3'd0},
        '{64'hFFFF_FFFF_FFFF_FFF2, 64'h8000_0000_0000_0003, 5'd31, 32'h0000_FFFF, 32'h0000_0003, 32'h5555_5555, 24'h0,      3'd0},
        '{64'h1234_0000_0000_0004, 64'h0000_5678_0000_0005, 5'd8,  32'h0000_0000, 32'hDEAD_BEEF, 32'h0F0F_0F0F, 24'h0,      3'd0},
        '{64'h0000_0001_0000_0006, 64'h7000_0000_0000_0007, 5'd4,  32'hF0F0_F0F0, 32'h8765_4321, 32'h0000_0000, 24'hABCDEF, 3'd7},
        '{64'h0400_0000_0000_0008, 64'h0400_0000_0000_0008, 5'd16, 32'hFFFF_0000, 32'h1111_2222, 32'h1111_2222, 24'h0,      3'd0},
        '{64'h0000_0000_00F0_000A, 64'h0000_0000_0F00_000B, 5'd1,  32'h8000_0001, 32'h8000_0001, 32'h0000_0000, 24'h0,      3'd0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mem_rd, mem_wr, ins_rd;
    logic [63:0]  mem_addr;
    logic [31:0]  mem_wdata;
    logic [31:0]  mem_rdata = '0;
    logic [255:0] ins_rdata = '0;

    logic [31:0]  dmem [16];
    logic [255:0] imem [8];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rmm_sequencer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .ins_rd    (ins_rd),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .ins_rdata (ins_rdata)
    );

    // Memory model: one-cycle read latency, write on the edge.
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= dmem[mem_addr[3:0]];
        if (ins_rd) ins_rdata <= imem[mem_addr[2:0]];
        if (mem_wr) dmem[mem_addr[3:0]] <= mem_wdata;
    end

    function automatic logic [63:0] next_of(input int k);
        return 64'hC000_0000_0000_0000 | 64'(k + 1);
    endfunction

    function automatic logic [31:0] exp_merge(input logic [31:0] s, input logic [31:0] d,
                                              input logic [31:0] m, input logic [4:0] r);
        logic [31:0] rt;
        logic [31:0] res;
        for (int i = 0; i < 32; i++) rt[(i + int'(r)) % 32] = s[i];
        for (int i = 0; i < 32; i++) res[i] = m[i] ? rt[i] : d[i];
        return res;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic strobes(input string req, input logic r, input logic w, input logic f);
        check(req, {61'd0, mem_rd, mem_wr, ins_rd}, {61'd0, r, w, f});
    endtask

    initial begin
        for (int i = 0; i < 16; i++) dmem[i] = '0;
        for (int i = 0; i < 8; i++) imem[i] = '0;
        for (int k = 0; k < NV; k++) begin
            dmem[VEC[k].src[3:0]] = VEC[k].sword;
            dmem[VEC[k].dst[3:0]] = VEC[k].dword;
            imem[k] = {VEC[k].junk, VEC[k].stp, VEC[k].rot, VEC[k].mask,
                       next_of(k), VEC[k].dst, VEC[k].src};
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: still in reset, fetch from zero.
        strobes("R1 strobes in reset", 1'b0, 1'b0, 1'b1);
        check("R1 boot address", mem_addr, 64'h0);
        rst_n = 1'b1;
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            // R2 (vector 3 also R7: junk upper bits and step 7 stored)
            strobes(k == 3 ? "R7 source pass strobes" : "R2 source pass strobes", 1'b1, 1'b0, 1'b0);
            check(k == 3 ? "R7 source address" : "R2 source address", mem_addr, VEC[k].src);
            @(negedge clk);
            strobes("R3 destination read strobes", 1'b1, 1'b0, 1'b0);
            check("R3 destination read address", mem_addr, VEC[k].dst);
            @(negedge clk);
            strobes("R4 write strobes", 1'b0, 1'b1, 1'b0);
            check("R4 write address", mem_addr, VEC[k].dst);
            check("R5 merged data", {32'd0, mem_wdata},
                  {32'd0, exp_merge(VEC[k].sword, VEC[k].dword, VEC[k].mask, VEC[k].rot)});
            @(negedge clk);
            strobes("R6 fetch strobes", 1'b0, 1'b0, 1'b1);
            check("R6 next address", mem_addr, next_of(k));
        end
        // R9: reset mid-instruction, one cycle into the next instruction.
        @(negedge clk);
        strobes("R8 single strobe", 1'b1, 1'b0, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        strobes("R9 strobes after mid reset", 1'b0, 1'b0, 1'b1);
        check("R9 refetch address", mem_addr, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        strobes("R9 restart source strobes", 1'b1, 1'b0, 1'b0);
        check("R9 restart source address", mem_addr, VEC[0].src);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule